// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory request issued on behalf of a full warp of lanes and reduces it to the smallest list of aligned memory transactions. Each request carries one byte address per lane, a mask of active lanes, an element-size code and a granularity mode. The block captures the entire request before it issues anything. It then finds every distinct 128-byte aligned line that the active lanes touch. For each line it builds a 4-bit mask of the 32-byte sectors that are actually referenced.

Transactions leave on a valid/ready stream, one per cycle, in ascending line order. While `txn_ready` is low, the current transaction is held unchanged. A new request is accepted only after the last transaction of the current one has been taken. A one-cycle `done` pulse closes each request. While `done` is high, the statistics outputs hold the final values for that request: the transaction count, the requested bytes and the transferred bytes. The transferred bytes count whole lines in line mode and only touched sectors in sector mode, so the access efficiency can be read straight from the ports.

Top module: `warp_coalescer`

## Requirements
- R1: `req_ready` is high only while no request is in progress. A request is taken on a cycle where `req_valid` and `req_ready` are both high. After that, `req_ready` stays low until `done` has pulsed.
- R2: Exactly one transaction is issued for each distinct 128-byte aligned line touched by an active lane. `txn_line` is the line index, which is the byte address shifted right by 7.
- R3: Within a request, transactions come out in strictly ascending `txn_line` order.
- R4: Bit k of `txn_sectors` is set exactly when some active lane's element lies in bytes 32k..32k+31 of that line.
- R5: Inactive lanes have no effect. If the mask is all zero, the request is accepted, `done` is high in the cycle after acceptance, and no transaction is issued.
- R6: `req_size` codes 0,1,2,3,4 mean elements of 1,2,4,8,16 bytes. Codes above 4 are treated as 16 bytes. When 32 lanes access consecutive elements from an aligned base, they produce 1 line for 4-byte elements, 2 lines for 8-byte elements and 4 lines for 16-byte elements.
- R7: Consider an element whose address is not a multiple of its size. Such an element raises `align_err` from the cycle after acceptance until the next acceptance, and it is placed using its address rounded down to the size.
- R8: While `done` is high, `req_bytes` equals the number of active lanes times the element size.
- R9: While `done` is high, `xfer_bytes` gives the bytes transferred. In line mode (`req_sector_mode`=0) this is 128 per transaction. In sector mode it is 32 per set sector bit, summed over all transactions.
- R10: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_line` and `txn_sectors` stay unchanged in the next cycle.
- R11: `done` pulses for exactly one cycle, in the cycle after the last transaction is taken. At that point `txn_count` equals the number of transactions issued, which is at most 32 and equals the lane stride N (in 4-byte words) for N from 1 to 32. A contiguous 128-byte span that starts 16 bytes into a line gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| req_mask | input | LANES | Active-lane mask |
| req_size | input | 3 | Element size code (R6) |
| req_sector_mode | input | 1 | 1 = sector-granular transfer accounting |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Consumer takes the transaction |
| txn_line | output | ADDR_W-7 | Aligned line index |
| txn_sectors | output | 4 | Touched sectors of the line |
| done | output | 1 | One-cycle end-of-request pulse |
| txn_count | output | $clog2(LANES+1) | Transactions issued for the request |
| req_bytes | output | $clog2(LANES*16+1) | Requested bytes |
| xfer_bytes | output | $clog2(LANES*128+1) | Transferred bytes |
| align_err | output | 1 | Some active element is misaligned |

## Verification
The main function is exercised with several kinds of lane stride. Unit stride from an aligned base must collapse into a single line. The same span shifted by 16 bytes must split into two lines. Strides of 2 to 32 words must grow the line count linearly, which separates correct merging from per-lane issue. Wide elements and a scrambled address set expose ordering and sector-mask errors, and half-masked, empty and misaligned requests probe the inactive-lane, accounting and rounding rules. The stream is driven partly under pseudo-random back-pressure, which checks that held transactions stay stable.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int LINE_OFF = 7;   // 128-byte lines
  localparam int SECT_OFF = 5;   // 32-byte sectors
  localparam int NSECT    = 4;
  localparam int MAX_SZ   = 4;   // log2 of the widest element

  typedef enum logic {ST_IDLE, ST_RUN} coal_state_e;

  function automatic logic [2:0] clamp_size(input logic [2:0] code);
    return (code > 3'(MAX_SZ)) ? 3'(MAX_SZ) : code;
  endfunction
endpackage

// File: rtl/coal_lane_decode.sv
module coal_lane_decode #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [2:0]                          size_log2,
  output logic [ADDR_W-coal_pkg::LINE_OFF-1:0] line,
  output logic [1:0]                          sector,
  output logic                                misal
);
  import coal_pkg::*;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] aligned;

  always_comb begin
    low_mask = (ADDR_W'(1) << size_log2) - ADDR_W'(1);
    aligned  = addr & ~low_mask;
    misal    = |(addr & low_mask);
    line     = aligned[ADDR_W-1:LINE_OFF];
    sector   = aligned[LINE_OFF-1:SECT_OFF];
  end
endmodule

// File: rtl/coal_min_tree.sv
module coal_min_tree #(
  parameter int N = 32,
  parameter int W = 25
) (
  input  logic [N-1:0]   vld,
  input  logic [N*W-1:0] keys,
  output logic           any,
  output logic [W-1:0]   min_key
);
  localparam int P = 1 << $clog2(N);

  logic         nv [1:2*P-1];
  logic [W-1:0] nk [1:2*P-1];

  genvar g;
  generate
    for (g = 0; g < P; g++) begin : g_leaf
      if (g < N) begin : g_real
        assign nv[P+g] = vld[g];
        assign nk[P+g] = keys[g*W +: W];
      end else begin : g_pad
        assign nv[P+g] = 1'b0;
        assign nk[P+g] = '0;
      end
    end
    for (g = 1; g < P; g++) begin : g_node
      logic take_r;
      assign take_r = nv[2*g+1] && (!nv[2*g] || (nk[2*g+1] < nk[2*g]));
      assign nv[g]  = nv[2*g] | nv[2*g+1];
      assign nk[g]  = take_r ? nk[2*g+1] : nk[2*g];
    end
  endgenerate

  assign any     = nv[1];
  assign min_key = nk[1];
endmodule

// File: rtl/coal_sector_merge.sv
module coal_sector_merge #(
  parameter int N  = 32,
  parameter int LW = 25
) (
  input  logic [N-1:0]    pending,
  input  logic [N*LW-1:0] lines,
  input  logic [N*2-1:0]  sectors,
  input  logic [LW-1:0]   sel_line,
  output logic [N-1:0]    match,
  output logic [3:0]      sect_mask
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match[g] = pending[g] && (lines[g*LW +: LW] == sel_line);
    end
  endgenerate

  always_comb begin
    sect_mask = '0;
    for (int i = 0; i < N; i++)
      if (match[i]) sect_mask[sectors[i*2 +: 2]] = 1'b1;
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  localparam int LW     = ADDR_W - coal_pkg::LINE_OFF,
  localparam int CNT_W  = $clog2(LANES + 1),
  localparam int REQB_W = $clog2(LANES * 16 + 1),
  localparam int XFER_W = $clog2(LANES * 128 + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_mask,
  input  logic [2:0]              req_size,
  input  logic                    req_sector_mode,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [LW-1:0]           txn_line,
  output logic [3:0]              txn_sectors,
  output logic                    done,
  output logic [CNT_W-1:0]        txn_count,
  output logic [REQB_W-1:0]       req_bytes,
  output logic [XFER_W-1:0]       xfer_bytes,
  output logic                    align_err
);
  import coal_pkg::*;

  coal_state_e             state;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        mask_q;
  logic [LANES-1:0]        pending;
  logic [2:0]              size_q;
  logic                    mode_q;

  logic [LANES*LW-1:0]     lane_line;
  logic [LANES*2-1:0]      lane_sect;
  logic [LANES-1:0]        lane_misal;
  logic                    any_pending;
  logic [LW-1:0]           min_line;
  logic [LANES-1:0]        match;
  logic [3:0]              sect_mask;
  logic                    accept, take;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      coal_lane_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr      (addr_q[g*ADDR_W +: ADDR_W]),
        .size_log2 (size_q),
        .line      (lane_line[g*LW +: LW]),
        .sector    (lane_sect[g*2 +: 2]),
        .misal     (lane_misal[g])
      );
    end
  endgenerate

  coal_min_tree #(.N(LANES), .W(LW)) u_min (
    .vld     (pending),
    .keys    (lane_line),
    .any     (any_pending),
    .min_key (min_line)
  );

  coal_sector_merge #(.N(LANES), .LW(LW)) u_merge (
    .pending   (pending),
    .lines     (lane_line),
    .sectors   (lane_sect),
    .sel_line  (min_line),
    .match     (match),
    .sect_mask (sect_mask)
  );

  assign req_ready   = (state == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign txn_valid   = (state == ST_RUN) && any_pending;
  assign txn_line    = min_line;
  assign txn_sectors = sect_mask;
  assign take        = txn_valid && txn_ready;
  assign done        = (state == ST_RUN) && !any_pending;
  assign align_err   = |(lane_misal & mask_q);
  assign req_bytes   = REQB_W'($countones(mask_q)) << size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      mask_q     <= '0;
      pending    <= '0;
      size_q     <= '0;
      mode_q     <= 1'b0;
      txn_count  <= '0;
      xfer_bytes <= '0;
    end else begin
      if (accept) begin
        state      <= ST_RUN;
        addr_q     <= req_addr;
        mask_q     <= req_mask;
        pending    <= req_mask;
        size_q     <= clamp_size(req_size);
        mode_q     <= req_sector_mode;
        txn_count  <= '0;
        xfer_bytes <= '0;
      end else if (take) begin
        pending   <= pending & ~match;
        txn_count <= txn_count + CNT_W'(1);
        if (mode_q)
          xfer_bytes <= xfer_bytes + (XFER_W'($countones(sect_mask)) << SECT_OFF);
        else
          xfer_bytes <= xfer_bytes + (XFER_W'(1) << LINE_OFF);
      end else if (done) begin
        state <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  localparam int LW    = ADDR_W - 7,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             txn_valid,
  input logic             txn_ready,
  input logic [LW-1:0]    txn_line,
  input logic [3:0]       txn_sectors,
  input logic             done,
  input logic [CNT_W-1:0] txn_count
);
  logic          have_prev;
  logic [LW-1:0] prev_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_line <= '0;
    end else if (req_valid && req_ready) begin
      have_prev <= 1'b0;
    end else if (txn_valid && txn_ready) begin
      have_prev <= 1'b1;
      prev_line <= txn_line;
    end
  end

  a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready);

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && have_prev) |-> (txn_line > prev_line));

  a_r4_sectors_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_sectors != 4'd0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_line) && $stable(txn_sectors)));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!txn_valid && txn_count <= CNT_W'(LANES)));
endmodule

bind warp_coalescer coal_checker #(.LANES(LANES), .ADDR_W(ADDR_W)) u_coal_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .txn_valid  (txn_valid),
  .txn_ready  (txn_ready),
  .txn_line   (txn_line),
  .txn_sectors(txn_sectors),
  .done       (done),
  .txn_count  (txn_count)
);

// File: tb/test_warp_coalescer.sv
module test_warp_coalescer;
  localparam int LANES = 32;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [LANES*AW-1:0] req_addr = '0;
  logic [LANES-1:0] req_mask = '0;
  logic [2:0]    req_size = '0;
  logic          req_sector_mode = 1'b0;
  logic          txn_valid;
  logic          txn_ready = 1'b1;
  logic [24:0]   txn_line;
  logic [3:0]    txn_sectors;
  logic          done;
  logic [5:0]    txn_count;
  logic [9:0]    req_bytes;
  logic [12:0]   xfer_bytes;
  logic          align_err;

  always #2 clk = ~clk;  // 250 MHz

  warp_coalescer #(.LANES(LANES), .ADDR_W(AW)) i_warp_coalescer (.*);

  int checks = 0, fails = 0;
  logic [31:0] lane_a [LANES];
  logic [28:0] exp_q [$];
  int exp_cnt, exp_xfer, exp_req, lit_cnt, lit_xfer;
  bit exp_err;
  int done_cnt = 0;
  bit bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  bit last_flag = 1'b0, stall_prev = 1'b0;
  logic [28:0] stall_item;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected transaction list from the requirements
  function automatic void build(input logic [31:0] mask, input int szc, input bit smode);
    logic [24:0] ul [LANES];
    logic [3:0]  us [LANES];
    int n = 0, sz, eff;
    eff = (szc > 4) ? 4 : szc;
    sz = 1 << eff;
    exp_err = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (mask[l]) begin
        logic [31:0] al;
        bit found = 1'b0;
        al = lane_a[l] & ~(32'(sz) - 32'd1);
        if (al != lane_a[l]) exp_err = 1'b1;
        for (int k = 0; k < n; k++)
          if (ul[k] == al[31:7]) begin us[k][al[6:5]] = 1'b1; found = 1'b1; end
        if (!found) begin
          ul[n] = al[31:7]; us[n] = 4'd0; us[n][al[6:5]] = 1'b1; n++;
        end
      end
    end
    for (int i = 1; i < n; i++)
      for (int j = i; j > 0 && ul[j] < ul[j-1]; j--) begin
        logic [24:0] tl; logic [3:0] ts;
        tl = ul[j]; ul[j] = ul[j-1]; ul[j-1] = tl;
        ts = us[j]; us[j] = us[j-1]; us[j-1] = ts;
      end
    exp_xfer = 0;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({ul[k], us[k]});
      exp_xfer += smode ? 32 * $countones(us[k]) : 128;
    end
    exp_cnt = n;
    exp_req = $countones(mask) * sz;
  endfunction

  task automatic run_req(input logic [31:0] mask, input int szc, input bit smode,
                         input int want_cnt, input int want_xfer);
    int d0;
    build(mask, szc, smode);
    lit_cnt = want_cnt; lit_xfer = want_xfer;
    d0 = done_cnt;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = lane_a[l];
    req_mask = mask; req_size = 3'(szc); req_sector_mode = smode;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
    if (mask == 0) chk(done == 1'b1, "R5 empty done next cycle", done, 1);
    while (done_cnt == d0) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        chk(txn_valid && {txn_line, txn_sectors} == stall_item, "R10 held under stall",
            {txn_line, txn_sectors}, stall_item);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      txn_ready = bp_en ? lfsr[0] : 1'b1;
      if (last_flag) begin
        chk(done == 1'b1, "R11 done after last", done, 1);
        last_flag = 1'b0;
      end
      stall_prev = txn_valid && !txn_ready;
      stall_item = {txn_line, txn_sectors};
      if (txn_valid && txn_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 extra transaction", txn_line, 0);
        else begin
          logic [28:0] e;
          e = exp_q.pop_front();
          chk(txn_line == e[28:4], "R2 R3 line", txn_line, e[28:4]);
          chk(txn_sectors == e[3:0], "R4 sectors", txn_sectors, e[3:0]);
          if (exp_q.size() == 0) last_flag = 1'b1;
        end
      end
      if (done) begin
        chk(exp_q.size() == 0, "R2 missing transactions", exp_q.size(), 0);
        chk(int'(txn_count) == exp_cnt, "R11 count", txn_count, exp_cnt);
        if (lit_cnt >= 0) chk(int'(txn_count) == lit_cnt, "R6 R11 literal count", txn_count, lit_cnt);
        chk(int'(xfer_bytes) == exp_xfer, "R9 xfer bytes", xfer_bytes, exp_xfer);
        if (lit_xfer >= 0) chk(int'(xfer_bytes) == lit_xfer, "R9 literal xfer", xfer_bytes, lit_xfer);
        chk(int'(req_bytes) == exp_req, "R8 req bytes", req_bytes, exp_req);
        chk(align_err == exp_err, "R7 align flag", align_err, exp_err);
        done_cnt++;
      end
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !txn_valid && !done, "R1 reset state", {req_ready, txn_valid, done}, 3'b100);
    // unit stride, 4-byte, aligned
    for (int l = 0; l < LANES; l++) lane_a[l] = 32'h1000 + 4*l;
    run_req('1, 2, 0, 1, 128);
    // same span offset by 16 bytes
    for (int l = 0; l < LANES; l++) lane_a[l] = 32'h1010 + 4*l;
    run_req('1, 2, 0, 2, 256);
    // word strides with back-pressure
    bp_en = 1'b1;
    for (int s = 2; s <= 32; s = s * 2) begin
      for (int l = 0; l < LANES; l++) lane_a[l] = 32'h4000 + 4*s*l;
      run_req('1, 2, 0, s, s * 128);
    end
    for (int l = 0; l < LANES; l++) lane_a[l] = 32'h4000 + 12*l;
    run_req('1, 2, 1, 3, -1);
    // wide elements (R6)
    for (int l = 0; l < LANES; l++) lane_a[l] = 32'h8000 + 8*l;
    run_req('1, 3, 0, 2, 256);
    for (int l = 0; l < LANES; l++) lane_a[l] = 32'h8000 + 16*l;
    run_req('1, 4, 1, 4, 512);
    run_req('1, 7, 0, 4, 512);
    // half warp active: sector vs line mode (R5, R9)
    for (int l = 0; l < LANES; l++) lane_a[l] = (l < 16) ? 32'h2000 + 4*l : 32'h9000 + 512*l;
    run_req(32'h0000FFFF, 2, 1, 1, 64);
    run_req(32'h0000FFFF, 2, 0, 1, 128);
    // empty mask (R5)
    run_req(32'h0, 2, 0, 0, 0);
    // misaligned 4-byte elements (R7)
    for (int l = 0; l < LANES; l++) lane_a[l] = 32'h3000 + 4*l + 1;
    run_req('1, 2, 0, 1, 128);
    // scrambled addresses, byte and halfword elements
    for (int l = 0; l < LANES; l++) lane_a[l] = 32'h6000 + ((l*13) % 32) * 96 + (l % 3) * 40;
    run_req(32'hF0F3_3CCF, 0, 1, -1, -1);
    run_req('1, 1, 0, -1, -1);
    bp_en = 1'b0;
    for (int l = 0; l < LANES; l++) lane_a[l] = 32'hFFFF_F000 - 128*l;
    run_req('1, 2, 0, 32, 4096);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R11 watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule